// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block holds the station address table of a learning bridge and is driven entirely by software. Software loads a 48-bit station address into a low data register and an attribute word into a high data register. It then issues a command: find an address, store an entry, invalidate an entry, fetch an entry by index, or purge every entry that belongs to a given port. A separate request wipes the whole table. Each command raises a busy flag, which software polls until the result is visible in the data registers and the result index.

The table is a simple dual-port memory scanned one entry at a time. This keeps the storage in block RAM and the compare logic down to a single comparator. A learned-entry counter sits beside the table. Software sets it to zero, steps it up or steps it down with explicit writes, and nothing else changes it. Memory contents are not reset, so software issues a wipe after reset before it uses the table.

Top module: `mac_addr_table`

## Requirements
- R1: After reset, `busy`, `wipe_busy`, `lo_rdata`, `hi_rdata`, `res_idx` and `lc_count` are all zero.
- R2: A command is accepted when `cmd_wr` is high while both `busy` and `wipe_busy` are low and `cmd_op` is a defined code (0 lookup, 1 write, 2 clear, 3 read, 4 port purge). `busy` is high from the edge that accepts the command until the edge that makes the result visible. `busy` and `wipe_busy` are never high together.
- R3: While `busy` or `wipe_busy` is high, `cmd_wr`, `wipe_req`, `lo_wr` and `hi_wr` have no effect. A `cmd_wr` carrying an undefined code (5 to 7) is ignored and does not raise `busy`.
- R4: Write (code 1) stores the data registers into the entry at index `cmd_arg[IDX_W-1:0]`, with `busy` high for exactly one cycle. Read (code 3) loads that entry into both data registers.
- R5: Clear (code 2) sets the entry at index `cmd_arg[IDX_W-1:0]` to all zeros, so the entry is invalid.
- R6: On a hit, lookup (code 0) sets `res_idx` to the lowest index whose entry is valid and holds the address in `lo_rdata`, and loads that entry's attribute word into `hi_rdata`. `lo_rdata` is left unchanged.
- R7: On a miss, lookup sets `res_idx` to the lowest invalid index, or to 0 when every entry is valid. `hi_rdata` then reads back with valid, static and priority at zero and every port-mask bit at one (0x01F for five ports).
- R8: Port purge (code 4) zeros every valid entry whose port mask shares a bit with `cmd_arg[NPORTS-1:0]`. All other entries are untouched.
- R9: An accepted `wipe_req` holds `wipe_busy` high for exactly DEPTH cycles and leaves every entry all zeros.
- R10: A pulse on `lc_wr` updates `lc_count` on the next edge according to `lc_mode`. Mode 0 sets the count to zero, mode 1 adds one and holds at DEPTH, mode 2 subtracts one and holds at 0, and mode 3 leaves it unchanged. Without `lc_wr` the count holds.
- R11: The attribute word is laid out as follows: port mask in bits [NPORTS-1:0], priority in the next PRIO_W bits, then the static bit, then the valid bit at the top. With the defaults these are mask [4:0], priority [7:5], static [8] and valid [9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | ARG_W | Entry index, or one-hot port set for a purge |
| busy | output | 1 | Command in progress |
| res_idx | output | IDX_W | Index given by the last command; lookup result |
| wipe_req | input | 1 | Request to wipe the whole table |
| wipe_busy | output | 1 | Wipe in progress |
| lo_wr | input | 1 | Load the address data register |
| lo_wdata | input | 48 | Address to load |
| lo_rdata | output | 48 | Address data register |
| hi_wr | input | 1 | Load the attribute data register |
| hi_wdata | input | HI_W | Attribute word to load |
| hi_rdata | output | HI_W | Attribute data register |
| lc_wr | input | 1 | Learned-count update strobe |
| lc_mode | input | 2 | Learned-count update mode |
| lc_count | output | CNT_W | Learned-entry count |

## Verification
Lookups are tried in four cases: an address held once, an address held in two slots (the lower index must win), a missing address with free slots, and a missing address in a full table. This separates the priority of a match from the choice of a free slot and from the fallback used when the table is full. Port purges use masks that overlap the purge set in a single bit, in several bits and in none, and one invalid entry carries a stale mask, which shows whether the valid bit gates the purge. Random mixes of writes, reads, clears, lookups and purges over a small address pool hit every slot many times against a bench model. Commands and data writes issued mid-scan show whether anything leaks into the table or the registers while the block is busy.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [2:0] {
    OP_LOOKUP = 3'd0,
    OP_WRITE  = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_READ   = 3'd3,
    OP_PDEL   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LC_ZERO = 2'd0,
    LC_INC  = 2'd1,
    LC_DEC  = 2'd2,
    LC_HOLD = 2'd3
  } lc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_LOAD, ST_SRD, ST_SEV, ST_DONE, ST_WIPE
  } st_e;

  function automatic logic op_defined(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/mac_tbl_ram.sv
module mac_tbl_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 58,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mac_tbl_match.sv
module mac_tbl_match #(
  parameter int NPORTS = 5,
  parameter int MAC_W  = 48
) (
  input  logic              ent_valid,
  input  logic [NPORTS-1:0] ent_mask,
  input  logic [MAC_W-1:0]  ent_mac,
  input  logic [MAC_W-1:0]  key_mac,
  input  logic [NPORTS-1:0] port_sel,
  output logic              hit,
  output logic              vacant,
  output logic              port_hit
);
  always_comb begin
    hit      = ent_valid && (ent_mac == key_mac);
    vacant   = !ent_valid;
    port_hit = ent_valid && (|(ent_mask & port_sel));
  end
endmodule

// File: rtl/mac_learn_cnt.sv
module mac_learn_cnt
  import mac_tbl_pkg::*;
#(
  parameter int MAXV = 16,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [1:0]   mode,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (upd) begin
      case (lc_e'(mode))
        LC_ZERO: count <= '0;
        LC_INC:  if (count != TOP) count <= count + 1'b1;
        LC_DEC:  if (count != '0)  count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mac_addr_table.sv
module mac_addr_table
  import mac_tbl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 5,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int HI_W  = NPORTS + PRIO_W + 2,
  localparam int ARG_W = (IDX_W > NPORTS) ? IDX_W : NPORTS,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_op,
  input  logic [ARG_W-1:0]  cmd_arg,
  output logic              busy,
  output logic [IDX_W-1:0]  res_idx,
  input  logic              wipe_req,
  output logic              wipe_busy,
  input  logic              lo_wr,
  input  logic [47:0]       lo_wdata,
  output logic [47:0]       lo_rdata,
  input  logic              hi_wr,
  input  logic [HI_W-1:0]   hi_wdata,
  output logic [HI_W-1:0]   hi_rdata,
  input  logic              lc_wr,
  input  logic [1:0]        lc_mode,
  output logic [CNT_W-1:0]  lc_count
);
  localparam int ENT_W = MAC_W + HI_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [HI_W-1:0] MISS_HI = {2'b00, {PRIO_W{1'b0}}, {NPORTS{1'b1}}};

  st_e               st;
  op_e               op_q;
  logic [IDX_W-1:0]  idx_q, hit_idx, free_idx;
  logic              found, free_found;
  logic [HI_W-1:0]   hit_hi;
  logic [NPORTS-1:0] port_q;
  logic [MAC_W-1:0]  lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              busy_q, wipe_q;
  logic [IDX_W-1:0]  res_q;

  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr, ram_raddr;
  logic [ENT_W-1:0]  ram_wdata, ram_rdata;
  logic [MAC_W-1:0]  rd_mac;
  logic [HI_W-1:0]   rd_hi;
  logic              m_hit, m_vacant, m_port_hit;

  logic idle, acc_cmd, acc_wipe, scan_op;

  assign rd_mac = ram_rdata[ENT_W-1:HI_W];
  assign rd_hi  = ram_rdata[HI_W-1:0];

  assign idle     = (st == ST_IDLE);
  assign acc_cmd  = cmd_wr && idle && op_defined(cmd_op);
  assign acc_wipe = wipe_req && idle && !acc_cmd;
  assign scan_op  = (cmd_op == OP_LOOKUP) || (cmd_op == OP_PDEL);

  mac_tbl_ram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  mac_tbl_match #(.NPORTS(NPORTS), .MAC_W(MAC_W)) u_match (
    .ent_valid (rd_hi[HI_W-1]),
    .ent_mask  (rd_hi[NPORTS-1:0]),
    .ent_mac   (rd_mac),
    .key_mac   (lo_q),
    .port_sel  (port_q),
    .hit       (m_hit),
    .vacant    (m_vacant),
    .port_hit  (m_port_hit)
  );

  mac_learn_cnt #(.MAXV(DEPTH)) u_lcnt (
    .clk   (clk),
    .rst   (rst),
    .upd   (lc_wr),
    .mode  (lc_mode),
    .count (lc_count)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = idx_q;
    ram_wdata = '0;
    ram_raddr = idx_q;
    case (st)
      ST_EXEC: begin
        if (op_q == OP_WRITE) begin
          ram_we    = 1'b1;
          ram_wdata = {lo_q, hi_q};
        end else if (op_q == OP_CLEAR) begin
          ram_we = 1'b1;
        end
      end
      ST_SEV:  if (op_q == OP_PDEL && m_port_hit) ram_we = 1'b1;
      ST_WIPE: ram_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_LOOKUP;
      idx_q      <= '0;
      hit_idx    <= '0;
      free_idx   <= '0;
      found      <= 1'b0;
      free_found <= 1'b0;
      hit_hi     <= '0;
      port_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      busy_q     <= 1'b0;
      wipe_q     <= 1'b0;
      res_q      <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (lo_wr) lo_q <= lo_wdata;
          if (hi_wr) hi_q <= hi_wdata;
          if (acc_cmd) begin
            op_q       <= op_e'(cmd_op);
            idx_q      <= scan_op ? '0 : cmd_arg[IDX_W-1:0];
            res_q      <= cmd_arg[IDX_W-1:0];
            port_q     <= cmd_arg[NPORTS-1:0];
            found      <= 1'b0;
            free_found <= 1'b0;
            hit_idx    <= '0;
            free_idx   <= '0;
            busy_q     <= 1'b1;
            st         <= scan_op ? ST_SRD : ST_EXEC;
          end else if (acc_wipe) begin
            idx_q  <= '0;
            wipe_q <= 1'b1;
            st     <= ST_WIPE;
          end
        end
        ST_EXEC: begin
          if (op_q == OP_READ) begin
            st <= ST_LOAD;
          end else begin
            busy_q <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          lo_q   <= rd_mac;
          hi_q   <= rd_hi;
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end
        ST_SRD: st <= ST_SEV;
        ST_SEV: begin
          if (op_q == OP_LOOKUP) begin
            if (m_hit && !found) begin
              found   <= 1'b1;
              hit_idx <= idx_q;
              hit_hi  <= rd_hi;
            end
            if (m_vacant && !free_found) begin
              free_found <= 1'b1;
              free_idx   <= idx_q;
            end
          end
          if (idx_q == LAST) begin
            st <= ST_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_SRD;
          end
        end
        ST_DONE: begin
          if (op_q == OP_LOOKUP) begin
            if (found) begin
              res_q <= hit_idx;
              hi_q  <= hit_hi;
            end else begin
              res_q <= free_idx;
              hi_q  <= MISS_HI;
            end
          end
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end
        ST_WIPE: begin
          if (idx_q == LAST) begin
            wipe_q <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign wipe_busy = wipe_q;
  assign lo_rdata  = lo_q;
  assign hi_rdata  = hi_q;
  assign res_idx   = res_q;
endmodule

// File: rtl/mac_tbl_chk.sv
module mac_tbl_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_wr,
  input logic [2:0]       cmd_op,
  input logic             wipe_req,
  input logic             busy,
  input logic             wipe_busy,
  input logic [47:0]      lo_rdata,
  input logic             lc_wr,
  input logic [1:0]       lc_mode,
  input logic [CNT_W-1:0] lc_count
);
  logic idle, acc_any;
  assign idle    = !busy && !wipe_busy;
  assign acc_any = cmd_wr && idle && (cmd_op <= 3'd4);

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(busy && wipe_busy));

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (rst)
    acc_any |=> busy);

  assert_write_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_any && cmd_op == 3'd1) |-> ##2 !busy);

  assert_bad_code_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && idle && cmd_op > 3'd4 && !wipe_req) |=> (!busy && !wipe_busy));

  assert_lo_held_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(lo_rdata));

  assert_wipe_start_R9: assert property (@(posedge clk) disable iff (rst)
    (wipe_req && idle && !acc_any) |=> wipe_busy);

  assert_cnt_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (lc_wr && lc_mode == 2'd0) |=> (lc_count == '0));

  assert_cnt_inc_R10: assert property (@(posedge clk) disable iff (rst)
    (lc_wr && lc_mode == 2'd1 && lc_count < CNT_W'(DEPTH)) |=>
      (lc_count == $past(lc_count) + 1'b1));

  assert_cnt_dec_R10: assert property (@(posedge clk) disable iff (rst)
    (lc_wr && lc_mode == 2'd2 && lc_count != '0) |=>
      (lc_count == $past(lc_count) - 1'b1));

  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !lc_wr |=> $stable(lc_count));
endmodule

bind mac_addr_table mac_tbl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_wr    (cmd_wr),
  .cmd_op    (cmd_op),
  .wipe_req  (wipe_req),
  .busy      (busy),
  .wipe_busy (wipe_busy),
  .lo_rdata  (lo_rdata),
  .lc_wr     (lc_wr),
  .lc_mode   (lc_mode),
  .lc_count  (lc_count)
);

// File: tb/test_mac_addr_table.sv
module test_mac_addr_table;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 16;
  localparam int NP    = 5;
  localparam int IW    = 4;
  localparam int HW    = 10;
  localparam int AW    = 5;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wr = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_arg = '0;
  logic          busy;
  logic [IW-1:0] res_idx;
  logic          wipe_req = 1'b0;
  logic          wipe_busy;
  logic          lo_wr = 1'b0;
  logic [47:0]   lo_wdata = '0;
  logic [47:0]   lo_rdata;
  logic          hi_wr = 1'b0;
  logic [HW-1:0] hi_wdata = '0;
  logic [HW-1:0] hi_rdata;
  logic          lc_wr = 1'b0;
  logic [1:0]    lc_mode = '0;
  logic [CW-1:0] lc_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [47:0]   m_mac [DEPTH];
  logic [HW-1:0] m_hi  [DEPTH];
  logic [47:0]   m_lo;
  int            m_cnt;

  always #2.5 clk = ~clk;

  mac_addr_table i_mac_addr_table (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .busy(busy), .res_idx(res_idx), .wipe_req(wipe_req), .wipe_busy(wipe_busy),
    .lo_wr(lo_wr), .lo_wdata(lo_wdata), .lo_rdata(lo_rdata),
    .hi_wr(hi_wr), .hi_wdata(hi_wdata), .hi_rdata(hi_rdata),
    .lc_wr(lc_wr), .lc_mode(lc_mode), .lc_count(lc_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [HW-1:0] mk_hi(input bit v, input bit s,
                                          input logic [2:0] p, input logic [NP-1:0] m);
    return {v, s, p, m};
  endfunction

  function automatic logic [47:0] pool_mac(input int k);
    return 48'h0200_0000_0000 + 48'(k) * 48'h0000_1111_0101;
  endfunction

  task automatic set_lo(input logic [47:0] v);
    lo_wr = 1'b1; lo_wdata = v; tick(); lo_wr = 1'b0; m_lo = v;
  endtask

  task automatic set_hi(input logic [HW-1:0] v);
    hi_wr = 1'b1; hi_wdata = v; tick(); hi_wr = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] arg);
    cmd_wr = 1'b1; cmd_op = op; cmd_arg = arg; tick(); cmd_wr = 1'b0;
    while (busy) tick();
  endtask

  task automatic do_write(input int idx, input logic [47:0] mac, input logic [HW-1:0] hi);
    set_lo(mac); set_hi(hi);
    run_cmd(3'd1, AW'(idx));
    m_mac[idx] = mac; m_hi[idx] = hi;
  endtask

  task automatic do_read(input int idx, input string req);
    run_cmd(3'd3, AW'(idx));
    chk(req, 64'(lo_rdata), 64'(m_mac[idx]));
    chk(req, 64'(hi_rdata), 64'(m_hi[idx]));
    m_lo = m_mac[idx];
  endtask

  task automatic do_clear(input int idx);
    run_cmd(3'd2, AW'(idx));
    m_mac[idx] = '0; m_hi[idx] = '0;
  endtask

  task automatic do_pdel(input logic [NP-1:0] sel);
    run_cmd(3'd4, AW'(sel));
    for (int i = 0; i < DEPTH; i++)
      if (m_hi[i][HW-1] && |(m_hi[i][NP-1:0] & sel)) begin
        m_mac[i] = '0; m_hi[i] = '0;
      end
  endtask

  task automatic mdl_lookup(input logic [47:0] key, output int ri, output logic [HW-1:0] rh);
    int fi;
    ri = -1; fi = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (ri < 0 && m_hi[i][HW-1] && m_mac[i] == key) ri = i;
      if (fi < 0 && !m_hi[i][HW-1]) fi = i;
    end
    if (ri >= 0) rh = m_hi[ri];
    else begin
      rh = mk_hi(0, 0, 3'd0, '1);
      ri = (fi >= 0) ? fi : 0;
    end
  endtask

  task automatic do_lookup(input logic [47:0] key, input string req);
    int ei;
    logic [HW-1:0] eh;
    set_lo(key);
    run_cmd(3'd0, '0);
    mdl_lookup(key, ei, eh);
    chk(req, 64'(res_idx), 64'(ei));
    chk(req, 64'(hi_rdata), 64'(eh));
    chk(req, 64'(lo_rdata), 64'(key));
  endtask

  task automatic do_wipe();
    int n;
    wipe_req = 1'b1; tick(); wipe_req = 1'b0;
    n = 0;
    while (wipe_busy) begin n++; tick(); end
    chk("R9 wipe length", 64'(n), 64'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin m_mac[i] = '0; m_hi[i] = '0; end
  endtask

  task automatic lc(input logic [1:0] mode);
    lc_wr = 1'b1; lc_mode = mode; tick(); lc_wr = 1'b0;
    case (mode)
      2'd0: m_cnt = 0;
      2'd1: if (m_cnt < DEPTH) m_cnt++;
      2'd2: if (m_cnt > 0) m_cnt--;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ei;
    logic [HW-1:0] eh;
    void'($urandom(32'd4242));
    m_cnt = 0; m_lo = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset values
    chk("R1 busy", 64'(busy), 0);
    chk("R1 wipe_busy", 64'(wipe_busy), 0);
    chk("R1 lo", 64'(lo_rdata), 0);
    chk("R1 hi", 64'(hi_rdata), 0);
    chk("R1 res_idx", 64'(res_idx), 0);
    chk("R1 count", 64'(lc_count), 0);

    // R9 wipe, then every entry reads zero
    do_wipe();
    for (int i = 0; i < DEPTH; i += 5) do_read(i, "R9 entry zero");

    // R4 R11 write one cycle busy, read back
    set_lo(pool_mac(1)); set_hi(mk_hi(1, 1, 3'd5, 5'b00110));
    cmd_wr = 1'b1; cmd_op = 3'd1; cmd_arg = 5'd2; tick(); cmd_wr = 1'b0;
    chk("R2 busy after accept", 64'(busy), 1);
    tick();
    chk("R4 busy one cycle", 64'(busy), 0);
    m_mac[2] = pool_mac(1); m_hi[2] = mk_hi(1, 1, 3'd5, 5'b00110);
    do_read(2, "R4 read back");
    chk("R11 valid bit", 64'(hi_rdata[9]), 1);
    chk("R11 prio field", 64'(hi_rdata[7:5]), 5);

    // R6 hit, duplicate address: lowest index wins
    do_write(7, pool_mac(3), mk_hi(1, 0, 3'd1, 5'b00001));
    do_write(4, pool_mac(3), mk_hi(1, 0, 3'd2, 5'b01000));
    do_lookup(pool_mac(3), "R6 lowest hit");
    chk("R6 idx 4", 64'(res_idx), 4);
    // R7 miss with free slots: lowest invalid is 0
    do_lookup(pool_mac(9), "R7 miss");
    chk("R7 miss mask", 64'(hi_rdata), 64'h01f);

    // R5 clear
    do_clear(4);
    do_read(4, "R5 cleared");
    do_lookup(pool_mac(3), "R5 R6 after clear");

    // R3 command, wipe and data writes while busy
    set_lo(pool_mac(11));
    cmd_wr = 1'b1; cmd_op = 3'd0; cmd_arg = '0; tick();
    cmd_op = 3'd1; cmd_arg = 5'd2; lo_wr = 1'b1; lo_wdata = pool_mac(12);
    hi_wr = 1'b1; hi_wdata = '0; wipe_req = 1'b1; tick();
    cmd_wr = 1'b0; lo_wr = 1'b0; hi_wr = 1'b0; wipe_req = 1'b0;
    while (busy) tick();
    chk("R3 wipe ignored", 64'(wipe_busy), 0);
    chk("R3 lo kept", 64'(lo_rdata), 64'(pool_mac(11)));
    chk("R3 miss hi", 64'(hi_rdata), 64'h01f);
    do_read(2, "R3 entry untouched");
    // R3 undefined code
    cmd_wr = 1'b1; cmd_op = 3'd6; cmd_arg = 5'd2; tick(); cmd_wr = 1'b0;
    chk("R3 bad code no busy", 64'(busy), 0);

    // R7 full table miss
    for (int i = 0; i < DEPTH; i++)
      do_write(i, pool_mac(20 + i), mk_hi(1, 0, 3'(i), 5'(1 << (i % NP))));
    do_lookup(pool_mac(99), "R7 full miss");
    chk("R7 full idx0", 64'(res_idx), 0);
    do_lookup(pool_mac(33), "R6 full hit");

    // R8 port purge: one-bit and multi-bit overlap
    do_write(3, pool_mac(40), mk_hi(1, 1, 3'd0, 5'b10010));
    do_write(5, pool_mac(41), mk_hi(0, 0, 3'd0, 5'b00010)); // invalid, stale mask
    do_pdel(5'b00010);
    for (int i = 0; i < DEPTH; i++) do_read(i, "R8 purge one port");
    do_pdel(5'b10100);
    for (int i = 0; i < DEPTH; i += 3) do_read(i, "R8 purge two ports");

    // R10 learned count
    lc(2'd1); lc(2'd1); lc(2'd1);
    chk("R10 inc", 64'(lc_count), 3);
    lc(2'd2);
    chk("R10 dec", 64'(lc_count), 2);
    lc(2'd3);
    chk("R10 hold", 64'(lc_count), 2);
    lc(2'd0);
    chk("R10 zero", 64'(lc_count), 0);
    lc(2'd2);
    chk("R10 floor", 64'(lc_count), 0);
    for (int i = 0; i < DEPTH + 2; i++) lc(2'd1);
    chk("R10 ceiling", 64'(lc_count), DEPTH);

    // random mix against model
    do_wipe();
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom_range(0, 9);
      int idx = $urandom_range(0, DEPTH - 1);
      logic [47:0] mac = pool_mac($urandom_range(0, 7));
      if (sel < 4)
        do_write(idx, mac, mk_hi(($urandom_range(0, 3) != 0), 1'($urandom),
                                  3'($urandom), 5'($urandom)));
      else if (sel < 6) do_lookup(mac, "R6 R7 random lookup");
      else if (sel < 7) do_read(idx, "R4 random read");
      else if (sel < 8) do_clear(idx);
      else if (sel < 9) do_pdel(5'(1 << $urandom_range(0, NP - 1)));
      else begin
        lc(2'($urandom));
        chk("R10 random count", 64'(lc_count), 64'(m_cnt));
      end
    end
    for (int i = 0; i < DEPTH; i++) do_read(i, "R4 R5 R8 final table");
    mdl_lookup(m_lo, ei, eh);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule